// File: doc/BRIEF.md
# Dual-Target Interrupt Cause/Mask Controller

This block gathers thirty-two level-sensitive interrupt sources and presents them to two processor targets, a primary and a secondary. Each target has its own cause register, which records every source that has been high, and its own enable mask. A source reaches a target only when that target's mask bit for the source is set. Setting a bit in one mask and clearing it in the other steers a line to a single processor.

Software reaches the four registers over a simple synchronous register bus. A write of ones to a cause register acknowledges those sources for that target only. A mask write replaces the whole mask. Each target has an interrupt line. It also has a status pair, made of a valid flag and the index of its lowest-numbered pending source, so a handler can dispatch without scanning the cause word.

Top module: `irqc_dual_target`

## Requirements
- R1: A synchronous active-high reset clears both cause registers and both masks. After reset, both interrupt lines and both valid flags are low and every register reads zero.
- R2: A source input that is high at a clock edge sets its bit in both cause registers at that edge. The cause registers read back their latched bits at byte offset 0x00 (primary) and 0x08 (secondary).
- R3: Writing a cause register clears each bit written as 1 and leaves each bit written as 0 unchanged. This affects only the addressed target's cause register.
- R4: The masks sit at 0x04 (primary) and 0x0C (secondary). A write loads the whole word, a read returns it, and writing one target's mask never changes the other's.
- R5: A target's interrupt line is high exactly when its cause register ANDed with its mask is nonzero.
- R6: If a source is still high in the cycle its bit is acknowledged, that bit reads as set afterwards.
- R7: Writing zero to a target's mask and then all ones to its cause register leaves that target's interrupt line and valid flag low.
- R8: The valid flag is high when the target's pending set is nonzero. The 5-bit index then names the least-significant set bit of that set, so bit 0 gives index 0 and bit 31 gives index 31.
- R9: The address is a 6-bit byte offset. Any offset other than the four registers reads as zero, and a write to it changes no register.
- R10: Read data appears on the cycle after the read strobe and is zero in cycles that follow no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | 32 | Level-sensitive interrupt sources |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the strobe |
| irq_pri | output | 1 | Primary target interrupt |
| irq_sec | output | 1 | Secondary target interrupt |
| pri_valid | output | 1 | Primary target has a pending source |
| pri_index | output | 5 | Lowest pending source for the primary target |
| sec_valid | output | 1 | Secondary target has a pending source |
| sec_index | output | 5 | Lowest pending source for the secondary target |

## Verification
The bench acknowledges a source in one target and checks that the other target's cause bit survives. A design that shared one cause word across targets would lose it there. It holds a source high through its own acknowledge, which catches a design that lets the clear win over the level. It walks the lowest-index encoder through sources 0, 7, 12, 30 and 31: a reversed priority would report the highest bit, and an off-by-one would misname the end positions. It also writes an unmapped offset with all ones, which a decoder that matched only the low address bits would alias onto a real register.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  // Byte offsets of the four registers; the pairing cause/mask per target
  // is what the decoder relies on (even slot = cause, odd slot = mask).
  localparam int OFS_PRI_CAUSE = 'h00;
  localparam int OFS_PRI_MASK  = 'h04;
  localparam int OFS_SEC_CAUSE = 'h08;
  localparam int OFS_SEC_MASK  = 'h0C;
  localparam int NUM_TARGETS   = 2;
  localparam int NUM_REGS      = 2 * NUM_TARGETS;

  typedef enum logic [1:0] {
    SLOT_PRI_CAUSE = 2'd0,
    SLOT_PRI_MASK  = 2'd1,
    SLOT_SEC_CAUSE = 2'd2,
    SLOT_SEC_MASK  = 2'd3
  } reg_slot_e;

  function automatic int slot_offset(input int slot);
    case (slot)
      0:       return OFS_PRI_CAUSE;
      1:       return OFS_PRI_MASK;
      2:       return OFS_SEC_CAUSE;
      default: return OFS_SEC_MASK;
    endcase
  endfunction
endpackage

// File: rtl/irqc_decode.sv
module irqc_decode
  import irqc_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic [ADDR_W-1:0]   addr,
  output logic [NUM_REGS-1:0] sel
);
  // Full-width compare so that no unmapped offset aliases a register.
  for (genvar r = 0; r < NUM_REGS; r++) begin : g_sel
    assign sel[r] = (addr == ADDR_W'(slot_offset(r)));
  end
endmodule

// File: rtl/irqc_target_bank.sv
module irqc_target_bank #(
  parameter int NSRC = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] src_i,
  input  logic            cause_we,
  input  logic            mask_we,
  input  logic [NSRC-1:0] wdata,
  output logic [NSRC-1:0] cause_q,
  output logic [NSRC-1:0] mask_q,
  output logic [NSRC-1:0] pending
);
  logic [NSRC-1:0] ack_bits;

  assign ack_bits = cause_we ? wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      cause_q <= '0;
      mask_q  <= '0;
    end else begin
      // Set dominates clear: a live level survives its own acknowledge.
      cause_q <= (cause_q & ~ack_bits) | src_i;
      if (mask_we) mask_q <= wdata;
    end
  end

  assign pending = cause_q & mask_q;
endmodule

// File: rtl/irqc_lowest_set.sv
module irqc_lowest_set #(
  parameter int W = 32,
  localparam int IDX_W = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]     vec,
  output logic             valid,
  output logic [IDX_W-1:0] index
);
  always_comb begin
    valid = |vec;
    index = '0;
    // Scan downward so the last hit, the lowest bit, wins.
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) index = IDX_W'(i);
    end
  end
endmodule

// File: rtl/irqc_dual_target.sv
module irqc_dual_target
  import irqc_pkg::*;
#(
  parameter int NSRC   = 32,
  parameter int ADDR_W = 6,
  localparam int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NSRC-1:0]   src_i,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NSRC-1:0]   bus_wdata,
  output logic [NSRC-1:0]   bus_rdata,
  output logic              irq_pri,
  output logic              irq_sec,
  output logic              pri_valid,
  output logic [IDX_W-1:0]  pri_index,
  output logic              sec_valid,
  output logic [IDX_W-1:0]  sec_index
);
  logic [NUM_REGS-1:0] sel;
  logic [NSRC-1:0]     cause_arr [NUM_TARGETS];
  logic [NSRC-1:0]     mask_arr  [NUM_TARGETS];
  logic [NSRC-1:0]     pend_arr  [NUM_TARGETS];
  logic                valid_arr [NUM_TARGETS];
  logic [IDX_W-1:0]    index_arr [NUM_TARGETS];
  logic [NSRC-1:0]     reg_view  [NUM_REGS];
  logic [NSRC-1:0]     rdata_n;

  logic [NSRC-1:0] cause_pri, mask_pri, cause_sec, mask_sec;

  irqc_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr (bus_addr),
    .sel  (sel)
  );

  for (genvar t = 0; t < NUM_TARGETS; t++) begin : g_tgt
    irqc_target_bank #(.NSRC(NSRC)) u_bank (
      .clk      (clk),
      .rst      (rst),
      .src_i    (src_i),
      .cause_we (bus_wr & sel[2*t]),
      .mask_we  (bus_wr & sel[2*t+1]),
      .wdata    (bus_wdata),
      .cause_q  (cause_arr[t]),
      .mask_q   (mask_arr[t]),
      .pending  (pend_arr[t])
    );

    irqc_lowest_set #(.W(NSRC)) u_low (
      .vec   (pend_arr[t]),
      .valid (valid_arr[t]),
      .index (index_arr[t])
    );

    assign reg_view[2*t]   = cause_arr[t];
    assign reg_view[2*t+1] = mask_arr[t];
  end

  always_comb begin
    rdata_n = '0;
    for (int r = 0; r < NUM_REGS; r++) begin
      if (sel[r]) rdata_n = reg_view[r];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rdata_n;
    else             bus_rdata <= '0;
  end

  assign cause_pri = cause_arr[0];
  assign mask_pri  = mask_arr[0];
  assign cause_sec = cause_arr[1];
  assign mask_sec  = mask_arr[1];

  assign irq_pri   = valid_arr[0];
  assign irq_sec   = valid_arr[1];
  assign pri_valid = valid_arr[0];
  assign pri_index = index_arr[0];
  assign sec_valid = valid_arr[1];
  assign sec_index = index_arr[1];
endmodule

// File: rtl/irqc_dual_target_chk.sv
module irqc_dual_target_chk
  import irqc_pkg::*;
#(
  parameter int NSRC   = 32,
  parameter int ADDR_W = 6,
  localparam int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input logic              clk,
  input logic              rst,
  input logic [NSRC-1:0]   src_i,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [NSRC-1:0]   bus_wdata,
  input logic              irq_pri,
  input logic              irq_sec,
  input logic              pri_valid,
  input logic [IDX_W-1:0]  pri_index,
  input logic              sec_valid,
  input logic [IDX_W-1:0]  sec_index,
  input logic [NSRC-1:0]   cause_pri,
  input logic [NSRC-1:0]   mask_pri,
  input logic [NSRC-1:0]   cause_sec,
  input logic [NSRC-1:0]   mask_sec
);
  logic mapped;
  assign mapped = (bus_addr == ADDR_W'(OFS_PRI_CAUSE)) || (bus_addr == ADDR_W'(OFS_PRI_MASK)) ||
                  (bus_addr == ADDR_W'(OFS_SEC_CAUSE)) || (bus_addr == ADDR_W'(OFS_SEC_MASK));

  // R1
  reset_quiet_chk: assert property (@(posedge clk) rst |=> (!irq_pri && !irq_sec && mask_pri == '0 && mask_sec == '0));

  // R2
  level_latch_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (((cause_pri & $past(src_i)) == $past(src_i)) && ((cause_sec & $past(src_i)) == $past(src_i))));

  // R3
  ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == ADDR_W'(OFS_PRI_CAUSE)) |=> ((cause_pri & $past(bus_wdata & ~src_i)) == '0));

  // R4
  mask_load_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == ADDR_W'(OFS_SEC_MASK)) |=> (mask_sec == $past(bus_wdata) && mask_pri == $past(mask_pri)));

  // R8
  index_hit_chk: assert property (@(posedge clk) disable iff (rst)
    pri_valid |-> (cause_pri[pri_index] && mask_pri[pri_index]));

  // R8
  index_lowest_chk: assert property (@(posedge clk) disable iff (rst)
    sec_valid |-> ((cause_sec & mask_sec & ((NSRC'(1) << sec_index) - NSRC'(1))) == '0));

  // R5
  irq_agree_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_pri == pri_valid) && (irq_sec == sec_valid));

  // R9
  unmapped_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !mapped) |=> (mask_pri == $past(mask_pri) && mask_sec == $past(mask_sec)));
endmodule

bind irqc_dual_target irqc_dual_target_chk #(.NSRC(NSRC), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .src_i     (src_i),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .irq_pri   (irq_pri),
  .irq_sec   (irq_sec),
  .pri_valid (pri_valid),
  .pri_index (pri_index),
  .sec_valid (sec_valid),
  .sec_index (sec_index),
  .cause_pri (cause_pri),
  .mask_pri  (mask_pri),
  .cause_sec (cause_sec),
  .mask_sec  (mask_sec)
);

// File: tb/sim_irqc_dual_target.sv
module sim_irqc_dual_target;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] src_i = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_pri, irq_sec, pri_valid, sec_valid;
  logic [4:0]  pri_index, sec_index;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } rd_item_t;
  rd_item_t sb_q[$];
  logic rd_seen = 1'b0;

  always #5 clk = ~clk;

  irqc_dual_target u0 (
    .clk(clk), .rst(rst), .src_i(src_i), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_pri(irq_pri), .irq_sec(irq_sec), .pri_valid(pri_valid), .pri_index(pri_index),
    .sec_valid(sec_valid), .sec_index(sec_index)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard when read data is due.
  always @(posedge clk) rd_seen <= bus_rd;
  always @(negedge clk) begin
    if (rd_seen) begin
      if (sb_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R10: unexpected read data %h expected none", bus_rdata);
      end else begin
        rd_item_t it;
        it = sb_q.pop_front();
        check(it.tag, bus_rdata, it.exp);
      end
    end else if (!rst) begin
      check("R10 idle rdata", bus_rdata, 32'h0);
    end
  end

  task automatic do_write(input logic [5:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic do_read(input logic [5:0] a, input logic [31:0] exp, input string tag);
    rd_item_t it;
    it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic pulse_src(input logic [31:0] s);
    src_i = s;
    @(negedge clk);
    src_i = '0;
  endtask

  task automatic check_tgt(input string tag, input logic irq, input logic v, input logic [4:0] idx,
                           input logic eirq, input logic ev, input logic [4:0] eidx);
    check({tag, " irq"}, {31'b0, irq}, {31'b0, eirq});
    check({tag, " valid"}, {31'b0, v}, {31'b0, ev});
    if (ev) check({tag, " index"}, {27'b0, idx}, {27'b0, eidx});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check_tgt("R1 pri", irq_pri, pri_valid, pri_index, 1'b0, 1'b0, 5'd0);
    check_tgt("R1 sec", irq_sec, sec_valid, sec_index, 1'b0, 1'b0, 5'd0);
    do_read(6'h00, 32'h0, "R1 pri cause");
    do_read(6'h04, 32'h0, "R1 pri mask");
    do_read(6'h08, 32'h0, "R1 sec cause");
    do_read(6'h0C, 32'h0, "R1 sec mask");

    // R2 latch into both targets; R5 masked off
    pulse_src(32'h0000_0008);
    do_read(6'h00, 32'h0000_0008, "R2 pri cause latched");
    do_read(6'h08, 32'h0000_0008, "R2 sec cause latched");
    check_tgt("R5 masked pri", irq_pri, pri_valid, pri_index, 1'b0, 1'b0, 5'd0);

    // R4 mask steer to primary only; R5, R8
    do_write(6'h04, 32'h0000_0008);
    check_tgt("R5 steer pri", irq_pri, pri_valid, pri_index, 1'b1, 1'b1, 5'd3);
    check_tgt("R5 steer sec", irq_sec, sec_valid, sec_index, 1'b0, 1'b0, 5'd0);
    do_read(6'h04, 32'h0000_0008, "R4 pri mask readback");
    do_read(6'h0C, 32'h0, "R4 sec mask untouched");

    // R3 acknowledge primary only; zero write to secondary has no effect
    do_write(6'h00, 32'h0000_0008);
    do_read(6'h00, 32'h0, "R3 pri cause cleared");
    do_write(6'h08, 32'h0);
    do_read(6'h08, 32'h0000_0008, "R3 sec cause kept");
    check_tgt("R3 pri after ack", irq_pri, pri_valid, pri_index, 1'b0, 1'b0, 5'd0);

    // R6 level held through acknowledge
    src_i = 32'h0000_0020;
    @(negedge clk);
    do_write(6'h00, 32'h0000_0020);
    do_read(6'h00, 32'h0000_0020, "R6 held level survives ack");
    src_i = '0;
    @(negedge clk);
    do_write(6'h00, 32'h0000_0020);
    do_read(6'h00, 32'h0, "R6 cleared after level drops");

    // R8 lowest-first with several sources
    do_write(6'h08, 32'hFFFF_FFFF);
    pulse_src(32'h4000_1080);
    do_write(6'h04, 32'hFFFF_FFFF);
    check_tgt("R8 pri lowest 7", irq_pri, pri_valid, pri_index, 1'b1, 1'b1, 5'd7);
    do_write(6'h00, 32'h0000_0080);
    check_tgt("R8 pri next 12", irq_pri, pri_valid, pri_index, 1'b1, 1'b1, 5'd12);
    do_write(6'h0C, 32'h4000_0000);
    check_tgt("R8 sec 30", irq_sec, sec_valid, sec_index, 1'b1, 1'b1, 5'd30);

    // R8 boundaries: bit 0 and bit 31
    do_write(6'h00, 32'hFFFF_FFFF);
    pulse_src(32'h8000_0001);
    check_tgt("R8 pri bit0", irq_pri, pri_valid, pri_index, 1'b1, 1'b1, 5'd0);
    do_write(6'h00, 32'h0000_0001);
    check_tgt("R8 pri bit31", irq_pri, pri_valid, pri_index, 1'b1, 1'b1, 5'd31);

    // R7 quiesce secondary
    do_write(6'h0C, 32'h0);
    do_write(6'h08, 32'hFFFF_FFFF);
    check_tgt("R7 sec quiesced", irq_sec, sec_valid, sec_index, 1'b0, 1'b0, 5'd0);
    do_read(6'h08, 32'h0, "R7 sec cause empty");
    check_tgt("R7 pri unaffected", irq_pri, pri_valid, pri_index, 1'b1, 1'b1, 5'd31);

    // R9 unmapped offsets
    do_write(6'h10, 32'hFFFF_FFFF);
    do_write(6'h24, 32'hFFFF_FFFF);
    do_read(6'h10, 32'h0, "R9 unmapped read zero");
    do_read(6'h04, 32'hFFFF_FFFF, "R9 pri mask unchanged");
    do_read(6'h0C, 32'h0, "R9 sec mask unchanged");
    do_read(6'h08, 32'h0, "R9 sec cause unchanged");

    repeat (2) @(negedge clk);
    check("R10 scoreboard drained", 32'(sb_q.size()), 32'h0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule